// File: doc/BRIEF.md
# DMA Channel Programming Port

This block is the register front end of a multi-channel DMA controller. Software reaches it through two byte-wide I/O ports on a synchronous write strobe. A byte written to the command port names a function in its upper nibble and a channel in its low three bits. A byte written to the data port goes to whichever channel register the last command byte selected. Multi-byte registers are filled least significant byte first, through a byte pointer that advances on each data write.

Every channel holds a mask bit, a 24-bit start address, a 16-bit count and an 8-bit mode byte. The programmed count is the transfer length minus one. The block drives out, for every channel, an enable (the inverse of the mask), the address, the count and a direction bit taken from the mode byte. A transfer engine downstream uses these values. A typical programming sequence for one channel is: mask, address, count, mode, unmask.

A small sequencer tracks which register is selected and which byte comes next. Its states are ST_IDLE (nothing selected), ST_ADR0, ST_ADR1 and ST_ADR2 (address bytes low, middle, high), ST_CNT0 and ST_CNT1 (count bytes low, high) and ST_MODE (mode byte). The transitions are:
- Any command byte leaves the current state. Function 0x2 goes to ST_ADR0, 0x4 goes to ST_CNT0, 0x7 goes to ST_MODE, and every other function goes to ST_IDLE.
- Data writes step ST_ADR0 to ST_ADR1, ST_ADR1 to ST_ADR2, ST_ADR2 to ST_IDLE, ST_CNT0 to ST_CNT1, ST_CNT1 to ST_IDLE, and ST_MODE to ST_IDLE.
- A data write in ST_IDLE changes nothing.

Top module: `dpp_prog_port`

## Requirements
- R1: After reset every channel's enable is 0 and its address, count and direction outputs are 0.
- R2: A command byte with upper nibble 0x9 clears the enable of the channel in bits 2:0, and one with upper nibble 0xA sets it. No other channel is affected, and only command bytes change any enable.
- R3: A command byte with upper nibble 0x2 selects the address of the channel in bits 2:0. The next three data writes load address bits 7:0, then 15:8, then 23:16.
- R4: A command byte with upper nibble 0x4 selects the count. The next two data writes load count bits 7:0, then 15:8, and the value is stored as written (length minus one).
- R5: A command byte with upper nibble 0x7 selects the mode. One data write loads the mode byte, and the direction output is bit 3 of that byte: 0x4C gives 1 (device to memory) and 0x44 gives 0 (memory to device).
- R6: Data writes after the selected register's last byte are ignored until the next command byte.
- R7: Any new command byte resets the byte pointer, so reselecting a register after a partial load starts again at its low byte.
- R8: A command byte with any other upper nibble selects nothing. Data writes after it leave every channel unchanged.
- R9: Bit 3 of a command byte is ignored, and a register write reaches only the addressed channel.
- R10: A command byte never changes an address, count or direction value, and a cycle with no write strobe changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_sel | input | 1 | 0 = command port, 1 = data port |
| io_data | input | 8 | Write data byte |
| ch_enable | output | NCH | Per-channel enable (inverse of the mask) |
| ch_addr | output | NCH*24 | Per-channel start address, channel c in bits c*24 +: 24 |
| ch_count | output | NCH*16 | Per-channel count (length minus one), channel c in bits c*16 +: 16 |
| ch_to_mem | output | NCH | Per-channel direction: 1 = device to memory |

## Verification
The bench programs all eight channels with arithmetically distinct values and compares every field of every channel after each step.

It goes after the following corner cases, each of which a faulty design would get wrong in a visible way:
- **Pointer overrun:** extra data bytes are written after each register is full. A design that wraps its byte pointer would overwrite the low byte.
- **Partial loads:** a register is reselected part way through loading it. A design that keeps the old pointer would load the wrong byte lanes.
- **Unused function codes:** all eleven unused codes are swept, each followed by data bytes. A design that leaves a stale selection active would corrupt a channel.
- **Bit 3 of the command byte:** a command with bit 3 set is sent. A design that decodes this bit as part of the channel would reach the wrong channel or none.

// File: rtl/dpp_pkg.sv
package dpp_pkg;

    localparam int ADDR_W  = 24;
    localparam int CNT_W   = 16;
    localparam int MODE_W  = 8;
    localparam int DIR_BIT = 3;

    localparam logic [3:0] FN_ADDR   = 4'h2;
    localparam logic [3:0] FN_COUNT  = 4'h4;
    localparam logic [3:0] FN_MODE   = 4'h7;
    localparam logic [3:0] FN_MASK   = 4'h9;
    localparam logic [3:0] FN_UNMASK = 4'hA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADR0,
        ST_ADR1,
        ST_ADR2,
        ST_CNT0,
        ST_CNT1,
        ST_MODE
    } seq_state_e;

    typedef enum logic [3:0] {
        WR_NONE,
        WR_ADR0,
        WR_ADR1,
        WR_ADR2,
        WR_CNT0,
        WR_CNT1,
        WR_MODE,
        WR_MASK,
        WR_UNMASK
    } wr_op_e;

endpackage

// File: rtl/dpp_cmd_fsm.sv
module dpp_cmd_fsm
    import dpp_pkg::*;
#(
    parameter int CH_BITS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_wr,
    input  logic               io_sel,
    input  logic [7:0]         io_data,
    output wr_op_e             op,
    output logic [CH_BITS-1:0] op_chan
);

    seq_state_e         state_q, state_d;
    logic [CH_BITS-1:0] chan_q, chan_d;
    logic               cmd_wr, dat_wr;
    logic [3:0]         fn;

    assign cmd_wr = io_wr && !io_sel;
    assign dat_wr = io_wr && io_sel;
    assign fn     = io_data[7:4];

    // next state
    always_comb begin
        state_d = state_q;
        chan_d  = chan_q;
        if (cmd_wr) begin
            chan_d = io_data[CH_BITS-1:0];
            if (fn == FN_ADDR)       state_d = ST_ADR0;
            else if (fn == FN_COUNT) state_d = ST_CNT0;
            else if (fn == FN_MODE)  state_d = ST_MODE;
            else                     state_d = ST_IDLE;
        end else if (dat_wr) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADR0: state_d = ST_ADR1;
                ST_ADR1: state_d = ST_ADR2;
                ST_ADR2: state_d = ST_IDLE;
                ST_CNT0: state_d = ST_CNT1;
                ST_CNT1: state_d = ST_IDLE;
                ST_MODE: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
        end
    end

    // outputs
    always_comb begin
        op      = WR_NONE;
        op_chan = chan_q;
        if (cmd_wr) begin
            op_chan = io_data[CH_BITS-1:0];
            if (fn == FN_MASK)        op = WR_MASK;
            else if (fn == FN_UNMASK) op = WR_UNMASK;
            else                      op = WR_NONE;
        end else if (dat_wr) begin
            unique case (state_q)
                ST_IDLE: op = WR_NONE;
                ST_ADR0: op = WR_ADR0;
                ST_ADR1: op = WR_ADR1;
                ST_ADR2: op = WR_ADR2;
                ST_CNT0: op = WR_CNT0;
                ST_CNT1: op = WR_CNT1;
                ST_MODE: op = WR_MODE;
                default: op = WR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dpp_chan_select.sv
module dpp_chan_select #(
    parameter int CH_BITS = 3,
    localparam int NCH    = 1 << CH_BITS
) (
    input  logic [CH_BITS-1:0] chan,
    output logic [NCH-1:0]     hit
);

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign hit[g] = (chan == CH_BITS'(g));
    end

endmodule

// File: rtl/dpp_chan_regs.sv
module dpp_chan_regs
    import dpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  wr_op_e            op,
    input  logic [7:0]        wdata,
    output logic              enable,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  count,
    output logic              to_mem
);

    logic              mask_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [MODE_W-1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
            addr_q <= '0;
            cnt_q  <= '0;
            mode_q <= '0;
        end else if (hit) begin
            unique case (op)
                WR_NONE:   ;
                WR_ADR0:   addr_q[7:0]   <= wdata;
                WR_ADR1:   addr_q[15:8]  <= wdata;
                WR_ADR2:   addr_q[23:16] <= wdata;
                WR_CNT0:   cnt_q[7:0]    <= wdata;
                WR_CNT1:   cnt_q[15:8]   <= wdata;
                WR_MODE:   mode_q        <= wdata;
                WR_MASK:   mask_q        <= 1'b1;
                WR_UNMASK: mask_q        <= 1'b0;
                default:   ;
            endcase
        end
    end

    assign enable = !mask_q;
    assign addr   = addr_q;
    assign count  = cnt_q;
    assign to_mem = mode_q[DIR_BIT];

endmodule

// File: rtl/dpp_prog_port.sv
module dpp_prog_port
    import dpp_pkg::*;
#(
    parameter int CH_BITS = 3,
    localparam int NCH    = 1 << CH_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  io_wr,
    input  logic                  io_sel,
    input  logic [7:0]            io_data,
    output logic [NCH-1:0]        ch_enable,
    output logic [NCH*ADDR_W-1:0] ch_addr,
    output logic [NCH*CNT_W-1:0]  ch_count,
    output logic [NCH-1:0]        ch_to_mem
);

    wr_op_e             op;
    logic [CH_BITS-1:0] op_chan;
    logic [NCH-1:0]     hit;

    dpp_cmd_fsm #(.CH_BITS(CH_BITS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_sel  (io_sel),
        .io_data (io_data),
        .op      (op),
        .op_chan (op_chan)
    );

    dpp_chan_select #(.CH_BITS(CH_BITS)) u_sel (
        .chan (op_chan),
        .hit  (hit)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dpp_chan_regs u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hit[g]),
            .op     (op),
            .wdata  (io_data),
            .enable (ch_enable[g]),
            .addr   (ch_addr[g*ADDR_W +: ADDR_W]),
            .count  (ch_count[g*CNT_W +: CNT_W]),
            .to_mem (ch_to_mem[g])
        );
    end

endmodule

// File: rtl/dpp_port_checker.sv
module dpp_port_checker #(
    parameter int CH_BITS = 3,
    localparam int NCH    = 1 << CH_BITS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic              io_sel,
    input logic [7:0]        io_data,
    input logic [NCH-1:0]    ch_enable,
    input logic [NCH*24-1:0] ch_addr,
    input logic [NCH*16-1:0] ch_count,
    input logic [NCH-1:0]    ch_to_mem
);

    // R1: reset leaves every channel disabled
    a_r1_reset_disabled: assert property (@(posedge clk)
        !rst_n |=> (ch_enable == '0));

    // R2: mask command disables the addressed channel
    a_r2_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_sel && io_data[7:4] == 4'h9)
        |=> !ch_enable[$past(io_data[CH_BITS-1:0])]);

    // R2: unmask command enables the addressed channel
    a_r2_unmask: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_sel && io_data[7:4] == 4'hA)
        |=> ch_enable[$past(io_data[CH_BITS-1:0])]);

    // R2: enables move only on command writes
    a_r2_enable_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && !io_sel) |=> $stable(ch_enable));

    // R10: command bytes leave register contents alone
    a_r10_cmd_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_sel)
        |=> ($stable(ch_addr) && $stable(ch_count) && $stable(ch_to_mem)));

    // R10: idle cycles change nothing
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> ($stable(ch_addr) && $stable(ch_count)
                    && $stable(ch_to_mem) && $stable(ch_enable)));

endmodule

bind dpp_prog_port dpp_port_checker #(.CH_BITS(CH_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_sel    (io_sel),
    .io_data   (io_data),
    .ch_enable (ch_enable),
    .ch_addr   (ch_addr),
    .ch_count  (ch_count),
    .ch_to_mem (ch_to_mem)
);

// File: tb/dpp_prog_port_test.sv
module dpp_prog_port_test;

    localparam int CH_BITS = 3;
    localparam int NCH     = 1 << CH_BITS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              io_wr = 1'b0;
    logic              io_sel = 1'b0;
    logic [7:0]        io_data = 8'h00;
    logic [NCH-1:0]    ch_enable;
    logic [NCH*24-1:0] ch_addr;
    logic [NCH*16-1:0] ch_count;
    logic [NCH-1:0]    ch_to_mem;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic        m_en   [NCH];
    logic [23:0] m_addr [NCH];
    logic [15:0] m_cnt  [NCH];
    logic        m_dir  [NCH];

    always #4 clk = ~clk;

    dpp_prog_port #(.CH_BITS(CH_BITS)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_wr     (io_wr),
        .io_sel    (io_sel),
        .io_data   (io_data),
        .ch_enable (ch_enable),
        .ch_addr   (ch_addr),
        .ch_count  (ch_count),
        .ch_to_mem (ch_to_mem)
    );

    task automatic put(input logic sel, input logic [7:0] b);
        @(negedge clk);
        io_wr   = 1'b1;
        io_sel  = sel;
        io_data = b;
        @(negedge clk);
        io_wr   = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);
        put(1'b0, b);
    endtask

    task automatic dat(input logic [7:0] b);
        put(1'b1, b);
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < NCH; c++) begin
            checks++;
            if (ch_enable[c] !== m_en[c] || ch_addr[c*24 +: 24] !== m_addr[c]
                || ch_count[c*16 +: 16] !== m_cnt[c] || ch_to_mem[c] !== m_dir[c]) begin
                errors++;
                $display("FAIL %s ch%0d: en=%0b addr=%06h cnt=%04h dir=%0b expected en=%0b addr=%06h cnt=%04h dir=%0b",
                         req, c, ch_enable[c], ch_addr[c*24 +: 24], ch_count[c*16 +: 16],
                         ch_to_mem[c], m_en[c], m_addr[c], m_cnt[c], m_dir[c]);
            end
        end
    endtask

    function automatic logic [23:0] addr_of(input int c, input int k);
        return {8'(c * 17 + k + 1), 8'(c * 3 + 8'h40 + k), 8'(8'hA0 + c + k)};
    endfunction

    function automatic logic [15:0] cnt_of(input int c, input int k);
        return 16'(c * 1000 + 255 + k * 7);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_en[c] = 1'b0; m_addr[c] = '0; m_cnt[c] = '0; m_dir[c] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R8: data bytes straight after reset go nowhere
        dat(8'h5A); dat(8'hC3);
        check_all("R8");

        // Full programming sequence on every channel (R2 R3 R4 R5 R9)
        for (int c = 0; c < NCH; c++) begin
            logic [23:0] a;
            logic [15:0] n;
            logic [7:0]  md;
            a  = addr_of(c, 0);
            n  = cnt_of(c, 0);
            md = (c % 2 == 1) ? 8'h4C : 8'h44;
            cmd(8'h90 | 8'(c));
            check_all("R2");
            cmd(8'h20 | 8'(c));
            dat(a[7:0]);
            m_addr[c][7:0] = a[7:0];
            check_all("R3");
            dat(a[15:8]); dat(a[23:16]);
            m_addr[c] = a;
            check_all("R3");
            cmd(8'h40 | 8'(c));
            dat(n[7:0]);
            m_cnt[c][7:0] = n[7:0];
            check_all("R4");
            dat(n[15:8]);
            m_cnt[c] = n;
            check_all("R4");
            cmd(8'h70 | 8'(c));
            dat(md);
            m_dir[c] = md[3];
            check_all("R5");
            cmd(8'hA0 | 8'(c));
            m_en[c] = 1'b1;
            check_all("R2");
        end

        // R6: overruns past the last byte are dropped
        cmd(8'h22);
        dat(8'h11); dat(8'h22); dat(8'h33); dat(8'hEE); dat(8'hDD);
        m_addr[2] = 24'h332211;
        check_all("R6");
        cmd(8'h45);
        dat(8'h34); dat(8'h12); dat(8'hFF);
        m_cnt[5] = 16'h1234;
        check_all("R6");
        cmd(8'h73);
        dat(8'h44); dat(8'h4C);
        m_dir[3] = 1'b0;
        check_all("R6");

        // R7: reselect restarts at the low byte
        cmd(8'h21);
        dat(8'h99);
        m_addr[1][7:0] = 8'h99;
        check_all("R7");
        cmd(8'h21);
        dat(8'hA1); dat(8'hB2); dat(8'hC3);
        m_addr[1] = 24'hC3B2A1;
        check_all("R7");
        cmd(8'h46);
        dat(8'h77);
        cmd(8'h46);
        dat(8'h01); dat(8'h80);
        m_cnt[6] = 16'h8001;
        check_all("R7");

        // R8: unused function codes select nothing
        for (int f = 0; f < 16; f++) begin
            if (f != 2 && f != 4 && f != 7 && f != 9 && f != 10) begin
                cmd(8'(f << 4) | 8'(f % NCH));
                dat(8'hFF); dat(8'h00); dat(8'h5A);
                check_all("R8");
            end
        end
        // R8: data after a mask/unmask command is ignored too
        cmd(8'hA4);
        dat(8'hFF); dat(8'hFF); dat(8'hFF);
        check_all("R8");

        // R9: bit 3 of the command byte is ignored
        cmd(8'h9B);
        m_en[3] = 1'b0;
        check_all("R9");
        cmd(8'h2F);
        dat(8'h0D); dat(8'h0E); dat(8'h0F);
        m_addr[7] = 24'h0F0E0D;
        check_all("R9");
        cmd(8'h7E);
        dat(8'h4C);
        m_dir[6] = 1'b1;
        check_all("R9");

        // R2: mask every channel, then unmask the even ones
        for (int c = 0; c < NCH; c++) begin
            cmd(8'h90 | 8'(c));
            m_en[c] = 1'b0;
        end
        check_all("R2");
        for (int c = 0; c < NCH; c += 2) begin
            cmd(8'hA0 | 8'(c));
            m_en[c] = 1'b1;
        end
        check_all("R2");

        // R10: idle cycles leave every output in place
        repeat (5) @(negedge clk);
        check_all("R10");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule